// File: doc/BRIEF.md
# Trap-Return State Restorer

This block carries out the two ways of leaving a trap handler: return-and-skip (`done`) and return-and-reexecute (`retry`). Each trap level owns an entry that holds the saved PC, the saved next-PC, a packed saved-state word and a saved hypervisor-state byte. When a command arrives, the block reads the entry for the current trap level. It unpacks that entry into the program counters, the extended and integer condition codes, the address-space identifier, the processor-state register, the window pointer and, when the global-level option is built in, the global level and hypervisor state. The trap level then drops by one.

The trap-state entries sit in a small internal array. A trap-entry path or a debug path writes them through a write-only port. The trap level can be loaded directly. All restored registers change at the clock edge that accepts the command. A one-cycle completion pulse follows. A command issued at trap level 0 raises a one-cycle illegal-operation pulse and leaves every register unchanged.

Top module: `trap_return_unit`

## Requirements
- R1: After reset, every output is zero: counters, codes, identifier, processor state, window pointer, global level, hypervisor state, trap level and both pulses.
- R2: A `done` command (`cmd_retry_i`=0) at trap level L>0 loads `pc_o` with the saved next-PC of level L and loads `npc_o` with that value plus 4.
- R3: A `retry` command (`cmd_retry_i`=1) at trap level L>0 loads `pc_o` with the saved PC of level L and loads `npc_o` with the saved next-PC of level L.
- R4: The same command loads `asi_o` from saved-state bits 31:24. It loads `icc_o` from bits 35:32 and `xcc_o` from bits 39:36.
- R5: The processor state is saved-state bits 19:8 ANDed with 0xF3F. When the global-level option is present (GL_EN=1), bits 0, 10 and 11 are also cleared, which gives a mask of 0x33E.
- R6: Let v be saved-state bits 7:0. If v is not below NWIN, it is first reduced modulo NWIN. `cwp_o` becomes NWIN-1-v.
- R7: With GL_EN=1, `gl_o` is loaded from saved-state bits 42:40 and `hpstate_o` from that level's saved hypervisor byte. With GL_EN=0, both outputs stay zero.
- R8: A command at trap level L>0 uses the entry of level L and sets the trap level to L-1.
- R9: A command at trap level 0 pulses `illegal_o` for one cycle and changes no register.
- R10: Restored registers and the new trap level appear at the command's clock edge. `done_o` is high for exactly the following cycle. With no command, neither pulse is raised and no restored register changes.
- R11: A write stores an entry for levels 1..MAX_TL. Writes to level 0 or to any level above MAX_TL are dropped. A command in the same cycle as a write to its own level restores the contents held before that write.
- R12: `tl_ld_i` sets the trap level to `tl_val_i`, clamped to MAX_TL. The load is ignored in any cycle in which a command is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ts_we_i | input | 1 | Trap-state entry write strobe |
| ts_lvl_i | input | TLW | Level addressed by the write |
| ts_tpc_i | input | PC_W | Saved PC to store |
| ts_tnpc_i | input | PC_W | Saved next-PC to store |
| ts_state_i | input | 43 | Packed saved-state word to store |
| ts_hps_i | input | HPS_W | Saved hypervisor state to store |
| tl_ld_i | input | 1 | Load the trap level |
| tl_val_i | input | TLW | Trap level value to load |
| cmd_valid_i | input | 1 | Trap-return command |
| cmd_retry_i | input | 1 | 1 = retry, 0 = done |
| pc_o | output | PC_W | Program counter |
| npc_o | output | PC_W | Next program counter |
| xcc_o | output | 4 | Extended condition codes |
| icc_o | output | 4 | Integer condition codes |
| asi_o | output | 8 | Address-space identifier |
| pstate_o | output | 12 | Processor state |
| cwp_o | output | CWPW | Current window pointer |
| gl_o | output | 3 | Global level |
| hpstate_o | output | HPS_W | Hypervisor state |
| tl_o | output | TLW | Trap level |
| done_o | output | 1 | Command completed (one cycle) |
| illegal_o | output | 1 | Command issued at trap level 0 (one cycle) |

## Verification
An entry write and a return command can land in the same cycle. A trap-level load and a return command can also coincide. The bench forces both pairs on purpose. It writes new contents to the level about to be consumed while the command fires, and expects the old contents to be restored, with the new ones showing up on a later return at that level. It also issues a level load together with a command and expects the load to be lost. Random stimulus creates further overlaps, and a bench model applies the ordering rules to judge them.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int TS_W     = 43;
  localparam int CWP_LSB  = 0;
  localparam int PST_LSB  = 8;
  localparam int ASI_LSB  = 24;
  localparam int ICC_LSB  = 32;
  localparam int XCC_LSB  = 36;
  localparam int GL_LSB   = 40;
  localparam logic [11:0] PST_KEEP  = 12'hF3F;
  localparam logic [11:0] PST_GBANK = 12'hC01;

  typedef struct packed {
    logic [3:0]  xcc;
    logic [3:0]  icc;
    logic [7:0]  asi;
    logic [11:0] pst;
    logic [2:0]  gl;
  } ts_fields_t;
endpackage

// File: rtl/trs_store.sv
module trs_store #(
  parameter int MAX_TL = 6,
  parameter int PC_W   = 64,
  parameter int HPS_W  = 8,
  parameter int TLW    = $clog2(MAX_TL + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [TLW-1:0]         wlvl_i,
  input  logic [PC_W-1:0]        wtpc_i,
  input  logic [PC_W-1:0]        wtnpc_i,
  input  logic [trs_pkg::TS_W-1:0] wstate_i,
  input  logic [HPS_W-1:0]       whps_i,
  input  logic [TLW-1:0]         rlvl_i,
  output logic [PC_W-1:0]        rtpc_o,
  output logic [PC_W-1:0]        rtnpc_o,
  output logic [trs_pkg::TS_W-1:0] rstate_o,
  output logic [HPS_W-1:0]       rhps_o
);
  localparam int DEPTH = MAX_TL + 1;

  logic [PC_W-1:0]          tpc_q   [DEPTH];
  logic [PC_W-1:0]          tnpc_q  [DEPTH];
  logic [trs_pkg::TS_W-1:0] state_q [DEPTH];
  logic [HPS_W-1:0]         hps_q   [DEPTH];

  logic wr_ok, rd_ok;
  assign wr_ok = we_i && (wlvl_i != '0) && (32'(wlvl_i) <= MAX_TL);
  assign rd_ok = 32'(rlvl_i) <= MAX_TL;

  // slot 0 is never written and reads as zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < DEPTH; l++) begin
        tpc_q[l]   <= '0;
        tnpc_q[l]  <= '0;
        state_q[l] <= '0;
        hps_q[l]   <= '0;
      end
    end else if (wr_ok) begin
      tpc_q[wlvl_i]   <= wtpc_i;
      tnpc_q[wlvl_i]  <= wtnpc_i;
      state_q[wlvl_i] <= wstate_i;
      hps_q[wlvl_i]   <= whps_i;
    end
  end

  assign rtpc_o   = rd_ok ? tpc_q[rlvl_i]   : '0;
  assign rtnpc_o  = rd_ok ? tnpc_q[rlvl_i]  : '0;
  assign rstate_o = rd_ok ? state_q[rlvl_i] : '0;
  assign rhps_o   = rd_ok ? hps_q[rlvl_i]   : '0;
endmodule

// File: rtl/trs_cwp_map.sv
module trs_cwp_map #(
  parameter int NWIN = 8,
  parameter int CWPW = $clog2(NWIN)
) (
  input  logic [7:0]      raw_i,
  output logic [CWPW-1:0] cwp_o
);
  logic [7:0] red;

  if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
    assign red = 8'(raw_i[CWPW-1:0]);
  end else begin : g_mod
    assign red = raw_i % 8'(NWIN);
  end

  // stored pointer counts the opposite way
  assign cwp_o = CWPW'(NWIN - 1) - red[CWPW-1:0];

  logic unused_red;
  assign unused_red = ^red[7:CWPW];
endmodule

// File: rtl/trs_decode.sv
module trs_decode
  import trs_pkg::*;
#(
  parameter int PC_W  = 64,
  parameter int NWIN  = 8,
  parameter bit GL_EN = 1'b1,
  parameter int CWPW  = $clog2(NWIN)
) (
  input  logic              retry_i,
  input  logic [PC_W-1:0]   tpc_i,
  input  logic [PC_W-1:0]   tnpc_i,
  input  logic [TS_W-1:0]   state_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   npc_o,
  output ts_fields_t        fld_o,
  output logic [CWPW-1:0]   cwp_o
);
  localparam logic [11:0] PST_MASK = GL_EN ? (PST_KEEP & ~PST_GBANK) : PST_KEEP;

  always_comb begin
    if (retry_i) begin
      pc_o  = tpc_i;
      npc_o = tnpc_i;
    end else begin
      pc_o  = tnpc_i;
      npc_o = tnpc_i + PC_W'(4);
    end
  end

  always_comb begin
    fld_o.xcc = state_i[XCC_LSB +: 4];
    fld_o.icc = state_i[ICC_LSB +: 4];
    fld_o.asi = state_i[ASI_LSB +: 8];
    fld_o.pst = state_i[PST_LSB +: 12] & PST_MASK;
    fld_o.gl  = state_i[GL_LSB +: 3];
  end

  trs_cwp_map #(.NWIN(NWIN), .CWPW(CWPW)) u_cwp (
    .raw_i (state_i[CWP_LSB +: 8]),
    .cwp_o (cwp_o)
  );

  logic unused_gap;
  assign unused_gap = ^state_i[23:20];
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trs_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int NWIN   = 8,
  parameter bit GL_EN  = 1'b1,
  parameter int PC_W   = 64,
  parameter int HPS_W  = 8,
  localparam int TLW   = $clog2(MAX_TL + 1),
  localparam int CWPW  = $clog2(NWIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ts_we_i,
  input  logic [TLW-1:0]    ts_lvl_i,
  input  logic [PC_W-1:0]   ts_tpc_i,
  input  logic [PC_W-1:0]   ts_tnpc_i,
  input  logic [TS_W-1:0]   ts_state_i,
  input  logic [HPS_W-1:0]  ts_hps_i,
  input  logic              tl_ld_i,
  input  logic [TLW-1:0]    tl_val_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_retry_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   npc_o,
  output logic [3:0]        xcc_o,
  output logic [3:0]        icc_o,
  output logic [7:0]        asi_o,
  output logic [11:0]       pstate_o,
  output logic [CWPW-1:0]   cwp_o,
  output logic [2:0]        gl_o,
  output logic [HPS_W-1:0]  hpstate_o,
  output logic [TLW-1:0]    tl_o,
  output logic              done_o,
  output logic              illegal_o
);
  logic [PC_W-1:0]  rd_tpc, rd_tnpc, nx_pc, nx_npc;
  logic [TS_W-1:0]  rd_state;
  logic [HPS_W-1:0] rd_hps;
  ts_fields_t       nx_fld;
  logic [CWPW-1:0]  nx_cwp;

  logic [PC_W-1:0]  pc_q, npc_q;
  logic [3:0]       xcc_q, icc_q;
  logic [7:0]       asi_q;
  logic [11:0]      pst_q;
  logic [CWPW-1:0]  cwp_q;
  logic [2:0]       gl_q;
  logic [HPS_W-1:0] hps_q;
  logic [TLW-1:0]   tl_q, tl_clamp;
  logic             done_q, ill_q;

  logic fire, bad;
  assign fire = cmd_valid_i && (tl_q != '0);
  assign bad  = cmd_valid_i && (tl_q == '0);
  assign tl_clamp = (32'(tl_val_i) > MAX_TL) ? TLW'(MAX_TL) : tl_val_i;

  trs_store #(.MAX_TL(MAX_TL), .PC_W(PC_W), .HPS_W(HPS_W), .TLW(TLW)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ts_we_i),
    .wlvl_i   (ts_lvl_i),
    .wtpc_i   (ts_tpc_i),
    .wtnpc_i  (ts_tnpc_i),
    .wstate_i (ts_state_i),
    .whps_i   (ts_hps_i),
    .rlvl_i   (tl_q),
    .rtpc_o   (rd_tpc),
    .rtnpc_o  (rd_tnpc),
    .rstate_o (rd_state),
    .rhps_o   (rd_hps)
  );

  trs_decode #(.PC_W(PC_W), .NWIN(NWIN), .GL_EN(GL_EN), .CWPW(CWPW)) u_dec (
    .retry_i (cmd_retry_i),
    .tpc_i   (rd_tpc),
    .tnpc_i  (rd_tnpc),
    .state_i (rd_state),
    .pc_o    (nx_pc),
    .npc_o   (nx_npc),
    .fld_o   (nx_fld),
    .cwp_o   (nx_cwp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      npc_q  <= '0;
      xcc_q  <= '0;
      icc_q  <= '0;
      asi_q  <= '0;
      pst_q  <= '0;
      cwp_q  <= '0;
      tl_q   <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= fire;
      ill_q  <= bad;
      if (fire) begin
        pc_q  <= nx_pc;
        npc_q <= nx_npc;
        xcc_q <= nx_fld.xcc;
        icc_q <= nx_fld.icc;
        asi_q <= nx_fld.asi;
        pst_q <= nx_fld.pst;
        cwp_q <= nx_cwp;
        tl_q  <= tl_q - 1'b1;
      end else if (tl_ld_i && !cmd_valid_i) begin
        tl_q <= tl_clamp;
      end
    end
  end

  if (GL_EN) begin : g_gl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gl_q  <= '0;
        hps_q <= '0;
      end else if (fire) begin
        gl_q  <= nx_fld.gl;
        hps_q <= rd_hps;
      end
    end
  end else begin : g_nogl
    assign gl_q  = '0;
    assign hps_q = '0;
  end

  assign pc_o      = pc_q;
  assign npc_o     = npc_q;
  assign xcc_o     = xcc_q;
  assign icc_o     = icc_q;
  assign asi_o     = asi_q;
  assign pstate_o  = pst_q;
  assign cwp_o     = cwp_q;
  assign gl_o      = gl_q;
  assign hpstate_o = hps_q;
  assign tl_o      = tl_q;
  assign done_o    = done_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/trap_return_unit_chk.sv
module trap_return_unit_chk #(
  parameter int MAX_TL = 6,
  parameter int NWIN   = 8,
  parameter bit GL_EN  = 1'b1,
  parameter int PC_W   = 64,
  parameter int TLW    = 3,
  parameter int CWPW   = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cmd_valid_i,
  input logic            cmd_retry_i,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] npc_o,
  input logic [11:0]     pstate_o,
  input logic [CWPW-1:0] cwp_o,
  input logic [TLW-1:0]  tl_o,
  input logic            done_o,
  input logic            illegal_o
);
  localparam logic [11:0] LEGAL = GL_EN ? 12'h33E : 12'hF3F;

  AST_TL_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && (tl_o != '0) |=> done_o && !illegal_o && (tl_o == TLW'($past(tl_o) - 1'b1))); // R8

  AST_ZERO_TL_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && (tl_o == '0) |=> illegal_o && !done_o && (tl_o == '0)
      && $stable(pc_o) && $stable(npc_o) && $stable(pstate_o) && $stable(cwp_o)); // R9

  AST_DONE_NPC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !$past(cmd_retry_i) |-> npc_o == pc_o + PC_W'(4)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cmd_valid_i) |-> !done_o && !illegal_o && $stable(pc_o) && $stable(npc_o)
      && $stable(pstate_o) && $stable(cwp_o)); // R10

  AST_CWP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cwp_o) < NWIN); // R6

  AST_PSTATE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_o & ~LEGAL) == 12'h000); // R5

  AST_TL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tl_o) <= MAX_TL); // R12
endmodule

bind trap_return_unit trap_return_unit_chk #(
  .MAX_TL(MAX_TL), .NWIN(NWIN), .GL_EN(GL_EN), .PC_W(PC_W), .TLW(TLW), .CWPW(CWPW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_retry_i (cmd_retry_i),
  .pc_o        (pc_o),
  .npc_o       (npc_o),
  .pstate_o    (pstate_o),
  .cwp_o       (cwp_o),
  .tl_o        (tl_o),
  .done_o      (done_o),
  .illegal_o   (illegal_o)
);

// File: tb/trap_return_unit_tb.sv
`timescale 1ns/1ps
module trap_return_unit_tb;
  localparam int MAX_TL = 4;
  localparam int NWIN   = 6;
  localparam int PC_W   = 64;
  localparam int HPS_W  = 8;
  localparam int TLW    = 3;
  localparam int CWPW   = 3;
  localparam int TS_W   = 43;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              ts_we = 1'b0;
  logic [TLW-1:0]    ts_lvl = '0;
  logic [PC_W-1:0]   ts_tpc = '0, ts_tnpc = '0;
  logic [TS_W-1:0]   ts_state = '0;
  logic [HPS_W-1:0]  ts_hps = '0;
  logic              tl_ld = 1'b0;
  logic [TLW-1:0]    tl_val = '0;
  logic              cmd_v = 1'b0, cmd_r = 1'b0;

  logic [PC_W-1:0]  a_pc, a_npc, b_pc, b_npc;
  logic [3:0]       a_xcc, a_icc, b_xcc, b_icc;
  logic [7:0]       a_asi, b_asi;
  logic [11:0]      a_pst, b_pst;
  logic [CWPW-1:0]  a_cwp, b_cwp;
  logic [2:0]       a_gl, b_gl;
  logic [HPS_W-1:0] a_hps, b_hps;
  logic [TLW-1:0]   a_tl, b_tl;
  logic             a_done, a_ill, b_done, b_ill;

  trap_return_unit #(.MAX_TL(MAX_TL), .NWIN(NWIN), .GL_EN(1'b1), .PC_W(PC_W), .HPS_W(HPS_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ts_we_i(ts_we), .ts_lvl_i(ts_lvl), .ts_tpc_i(ts_tpc),
    .ts_tnpc_i(ts_tnpc), .ts_state_i(ts_state), .ts_hps_i(ts_hps), .tl_ld_i(tl_ld),
    .tl_val_i(tl_val), .cmd_valid_i(cmd_v), .cmd_retry_i(cmd_r), .pc_o(a_pc), .npc_o(a_npc),
    .xcc_o(a_xcc), .icc_o(a_icc), .asi_o(a_asi), .pstate_o(a_pst), .cwp_o(a_cwp), .gl_o(a_gl),
    .hpstate_o(a_hps), .tl_o(a_tl), .done_o(a_done), .illegal_o(a_ill));

  trap_return_unit #(.MAX_TL(MAX_TL), .NWIN(NWIN), .GL_EN(1'b0), .PC_W(PC_W), .HPS_W(HPS_W)) u_dut_nogl (
    .clk_i(clk), .rst_ni(rst_n), .ts_we_i(ts_we), .ts_lvl_i(ts_lvl), .ts_tpc_i(ts_tpc),
    .ts_tnpc_i(ts_tnpc), .ts_state_i(ts_state), .ts_hps_i(ts_hps), .tl_ld_i(tl_ld),
    .tl_val_i(tl_val), .cmd_valid_i(cmd_v), .cmd_retry_i(cmd_r), .pc_o(b_pc), .npc_o(b_npc),
    .xcc_o(b_xcc), .icc_o(b_icc), .asi_o(b_asi), .pstate_o(b_pst), .cwp_o(b_cwp), .gl_o(b_gl),
    .hpstate_o(b_hps), .tl_o(b_tl), .done_o(b_done), .illegal_o(b_ill));

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  // bench model
  logic [PC_W-1:0]  m_tpc [MAX_TL+1];
  logic [PC_W-1:0]  m_tnpc[MAX_TL+1];
  logic [TS_W-1:0]  m_ts  [MAX_TL+1];
  logic [HPS_W-1:0] m_hps [MAX_TL+1];
  int m_tl = 0;
  logic [PC_W-1:0] e_pc = '0, e_npc = '0;
  logic [3:0] e_xcc = '0, e_icc = '0;
  logic [7:0] e_asi = '0;
  logic [11:0] e_pst_a = '0, e_pst_b = '0;
  int e_cwp = 0;
  logic [2:0] e_gl = '0;
  logic [HPS_W-1:0] e_hps = '0;
  bit e_done = 0, e_ill = 0, e_retry = 0;

  function automatic int exp_cwp(logic [7:0] v);
    return NWIN - 1 - (int'(v) % NWIN);
  endfunction

  task automatic chk(string ctx, string tag, string name, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s [%s] %s: actual=%h expected=%h", tag, ctx, name, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    string pt;
    pt = e_retry ? "R3" : "R2";
    chk(ctx, pt,    "pc",        a_pc,  e_pc);
    chk(ctx, pt,    "npc",       a_npc, e_npc);
    chk(ctx, "R4",  "xcc",       64'(a_xcc), 64'(e_xcc));
    chk(ctx, "R4",  "icc",       64'(a_icc), 64'(e_icc));
    chk(ctx, "R4",  "asi",       64'(a_asi), 64'(e_asi));
    chk(ctx, "R5",  "pstate",    64'(a_pst), 64'(e_pst_a));
    chk(ctx, "R5",  "pstate_ng", 64'(b_pst), 64'(e_pst_b));
    chk(ctx, "R6",  "cwp",       64'(a_cwp), 64'(e_cwp));
    chk(ctx, "R7",  "gl",        64'(a_gl),  64'(e_gl));
    chk(ctx, "R7",  "hps",       64'(a_hps), 64'(e_hps));
    chk(ctx, "R7",  "gl_ng",     64'({b_gl, b_hps}), 64'(0));
    chk(ctx, "R8",  "tl",        64'(a_tl),  64'(m_tl));
    chk(ctx, "R10", "done",      64'(a_done), 64'(e_done));
    chk(ctx, "R9",  "illegal",   64'(a_ill),  64'(e_ill));
    chk(ctx, "R2",  "nogl_pc",   {b_pc ^ a_pc}, 64'(0));
  endtask

  task automatic step(string ctx, bit we, int lvl, logic [63:0] tpc, logic [63:0] tnpc,
                      logic [TS_W-1:0] st, logic [7:0] hps, bit ld, int ldv, bit cmd, bit retry);
    @(negedge clk);
    ts_we = we; ts_lvl = TLW'(lvl); ts_tpc = tpc; ts_tnpc = tnpc; ts_state = st; ts_hps = hps;
    tl_ld = ld; tl_val = TLW'(ldv); cmd_v = cmd; cmd_r = retry;
    @(posedge clk);
    #1;
    e_done = 0; e_ill = 0;
    if (cmd) begin
      if (m_tl == 0) e_ill = 1;
      else begin
        e_done = 1; e_retry = retry;
        e_pc  = retry ? m_tpc[m_tl] : m_tnpc[m_tl];
        e_npc = retry ? m_tnpc[m_tl] : m_tnpc[m_tl] + 64'd4;
        e_xcc = m_ts[m_tl][39:36];
        e_icc = m_ts[m_tl][35:32];
        e_asi = m_ts[m_tl][31:24];
        e_pst_a = m_ts[m_tl][19:8] & 12'h33E;
        e_pst_b = m_ts[m_tl][19:8] & 12'hF3F;
        e_cwp = exp_cwp(m_ts[m_tl][7:0]);
        e_gl  = m_ts[m_tl][42:40];
        e_hps = m_hps[m_tl];
        m_tl--;
      end
    end else if (ld) m_tl = (ldv > MAX_TL) ? MAX_TL : ldv;
    if (we && lvl >= 1 && lvl <= MAX_TL) begin
      m_tpc[lvl] = tpc; m_tnpc[lvl] = tnpc; m_ts[lvl] = st; m_hps[lvl] = hps;
    end
    ts_we = 0; tl_ld = 0; cmd_v = 0; cmd_r = 0;
    check_all(ctx);
  endtask

  function automatic logic [TS_W-1:0] rts();
    return TS_W'({$urandom, $urandom});
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int l = 0; l <= MAX_TL; l++) begin
      m_tpc[l] = '0; m_tnpc[l] = '0; m_ts[l] = '0; m_hps[l] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("reset", "R1", "outs_a", {a_pc ^ a_npc, 64'(0)} == 0 && a_pc == 0 ? 64'(0) : 64'(1), 64'(0));
    chk("reset", "R1", "fields_a", 64'({a_xcc, a_icc, a_asi, a_pst, a_cwp, a_gl, a_hps, a_tl, a_done, a_ill}), 64'(0));
    chk("reset", "R1", "fields_b", 64'({b_xcc, b_icc, b_asi, b_pst, b_cwp, b_gl, b_hps, b_tl, b_done, b_ill}), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;

    // R9: command at level 0
    step("tl0_done", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("tl0_retry", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);

    // R11: fill levels, then stray writes to nonexistent levels
    for (int l = 1; l <= MAX_TL; l++)
      step("fill", 1, l, 64'h1000 * l, 64'h1000 * l + 4, rts(), 8'(8'h10 + l), 0, 0, 0, 0);
    step("r11_lvl0", 1, 0, 64'hDEAD, 64'hBEEF, '1, 8'hFF, 0, 0, 0, 0);
    for (int l = MAX_TL + 1; l < (1 << TLW); l++)
      step("r11_hi", 1, l, 64'hDEAD, 64'hBEEF, '1, 8'hFF, 0, 0, 0, 0);

    // R12: clamp, then walk down with alternating flavours (R2 R3 R8)
    step("r12_clamp", 0, 0, 0, 0, 0, 0, 1, 7, 0, 0);
    for (int l = 0; l < MAX_TL; l++)
      step("walk", 0, 0, 0, 0, 0, 0, 0, 0, 1, l[0]);

    // R6: window pointer corner values; R5: all-ones processor state
    step("r6_set", 1, 1, 64'hA0, 64'hA4, {3'b101, 4'hF, 4'h3, 8'h5A, 4'h0, 12'hFFF, 8'd6}, 8'h77, 1, 1, 0, 0);
    step("r6_mod", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("r6_set2", 1, 1, 64'hB0, 64'hB4, {3'b010, 20'h0, 12'h000, 8'd255}, 8'h01, 1, 1, 0, 0);
    step("r6_255", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    step("r6_set3", 1, 1, 64'hC0, 64'hC4, {35'h0, 8'd5}, 8'h02, 1, 1, 0, 0);
    step("r6_top", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("r6_set4", 1, 1, 64'hD0, 64'hD4, {35'h0, 8'd0}, 8'h03, 1, 1, 0, 0);
    step("r6_zero", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);

    // R11: write and command to the same level in one cycle
    step("r11_pre", 1, 2, 64'h200, 64'h204, rts(), 8'h22, 1, 2, 0, 0);
    step("r11_same", 1, 2, 64'h900, 64'h904, rts(), 8'h99, 0, 0, 1, 1);
    step("r11_back", 0, 0, 0, 0, 0, 0, 1, 2, 0, 0);
    step("r11_new", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);

    // R12: load together with command is ignored
    step("r12_pre", 0, 0, 0, 0, 0, 0, 1, 3, 0, 0);
    step("r12_clash", 0, 0, 0, 0, 0, 0, 1, 4, 1, 0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      bit we, ld, cmd;
      we  = ($urandom_range(0, 1) == 1);
      ld  = ($urandom_range(0, 4) == 0);
      cmd = ($urandom_range(0, 4) < 2);
      step("rand", we, $urandom_range(0, 7), {$urandom, $urandom}, {$urandom, $urandom},
           rts(), 8'($urandom), ld, $urandom_range(0, 7), cmd, $urandom_range(0, 1) == 1);
    end

    // R10: idle cycles
    step("r10_idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("r10_idle2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule